// File: doc/BRIEF.md
# Sliding-Window Phase-Error Loop Filter

This block is the loop filter of a grid-synchronisation loop whose sampling period is itself the controlled quantity. Once per sample it receives a signed phase-error value, the q-axis component of the grid voltage after rotation by the locally generated phase. A running sum over exactly one grid period of samples (or half a period) removes every harmonic and unbalance component and leaves only the DC term. A proportional-plus-integral compensator then turns that DC term into the sampling-period word for the next period.

The window length is chosen by a mode input. Full length suits grids where even harmonics matter. Half length halves the useful sample history when they do not. Changing the mode restarts the window from empty. The period word is clamped to the nominal value plus or minus five percent. While the output is clamped, the integrator refuses steps that would push it deeper into the clamp.

Top module: `swf_loop_filter`

## Requirements
- R1: After reset, `period_word` equals NOM, `period_vld` is 0, and the window sum and integrator are zero.
- R2: Each accepted sample updates a window sum S that equals the sum of the last Nw accepted samples since the last clear, with missing samples counting as zero.
- R3: Nw is NMAX when `half_mode` is 0, and NMAX/2 when `half_mode` is 1.
- R4: A stream that repeats every Nw samples with zero mean gives S = 0 once the window is full, and from then on `period_word` does not change.
- R5: In a cycle where `half_mode` differs from the mode in use, the window storage, S and the write position are cleared, the new mode takes effect, and a strobe in that cycle is discarded with no valid output. The integrator is kept.
- R6: With p = floor(S / 2^P_SH), i = floor(S / 2^I_SH) and integrator I, the candidate is I' = I + i and the output is NOM + p + I_next, where I_next is I' unless R8 applies.
- R7: `period_word` stays between NOM − NOM/20 and NOM + NOM/20 (integer division) and is clamped to the nearer bound when outside.
- R8: If NOM + p + I' is above the upper bound while i > 0, or below the lower bound while i < 0, then I_next = I.
- R9: `period_vld` pulses for one cycle, two clock edges after the edge that samples an accepted `err_stb`. No pulse occurs otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| half_mode | input | 1 | 1 selects a window of NMAX/2 samples, 0 selects NMAX |
| err_stb | input | 1 | Qualifies `err_in` for one cycle |
| err_in | input | DW | Signed phase-error sample |
| period_word | output | PW | Sampling-period word, clamped |
| period_vld | output | 1 | One-cycle pulse when a new period word is available |

## Verification
The bench builds the block with DW = 8, NMAX = 8, NOM = 1000, P_SH = 2 and I_SH = 4. With these values the bounds are 950 and 1050, and a few full-scale samples drive the output into either clamp. Both window lengths are filled and wrapped many times. The stream crosses mode changes in both directions. A zero-mean pattern of one window period shows the output settling. Full-scale runs of each sign then exercise the clamp and show that the integrator comes back out without windup delay.

// File: rtl/swf_pkg.sv
package swf_pkg;

  typedef struct packed {
    logic signed [31:0] integ;
    logic        [31:0] word;
    logic               hi;
    logic               lo;
    logic               frz;
  } comp_t;

  // Arithmetic right shift = floor division by 2^sh
  function automatic int floor_shr(input int v, input int sh);
    return v >>> sh;
  endfunction

  // Clamp to [lo_b, hi_b]
  function automatic int clamp(input int v, input int lo_b, input int hi_b);
    if (v > hi_b) return hi_b;
    if (v < lo_b) return lo_b;
    return v;
  endfunction

  // One compensator step: proportional + integral with directional anti-windup
  function automatic comp_t comp_step(input int integ, input int sum, input int nom,
                                      input int pmin, input int pmax,
                                      input int psh, input int ish);
    comp_t r;
    int p, i, cand, raw, keep, fin;
    p    = floor_shr(sum, psh);
    i    = floor_shr(sum, ish);
    cand = integ + i;
    raw  = nom + p + cand;
    r.frz   = ((raw > pmax) && (i > 0)) || ((raw < pmin) && (i < 0));
    keep    = r.frz ? integ : cand;
    fin     = nom + p + keep;
    r.hi    = fin > pmax;
    r.lo    = fin < pmin;
    r.word  = clamp(fin, pmin, pmax);
    r.integ = keep;
    return r;
  endfunction

endpackage

// File: rtl/swf_window.sv
module swf_window #(
  parameter int DW   = 12,
  parameter int NMAX = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  half_mode,
  input  logic                  stb,
  input  logic signed [DW-1:0]  err,
  output logic signed [DW+$clog2(NMAX):0] sum,
  output logic                  sum_vld,
  output logic                  flip
);
  localparam int AW   = $clog2(NMAX);
  localparam int SW   = DW + AW + 1;
  localparam int HALF = NMAX / 2;
  localparam logic [AW-1:0] LAST_FULL = AW'(NMAX - 1);
  localparam logic [AW-1:0] LAST_HALF = AW'(HALF - 1);

  logic                 mode_q;
  logic signed [DW-1:0] ring_q [NMAX];
  logic [AW-1:0]        wr_ptr;
  logic signed [SW-1:0] acc_q;
  logic [AW-1:0]        last_idx;
  logic signed [DW-1:0] oldest;
  logic signed [SW-1:0] acc_nxt;

  assign flip     = (half_mode != mode_q);
  assign last_idx = mode_q ? LAST_HALF : LAST_FULL;
  assign oldest   = ring_q[wr_ptr];
  assign acc_nxt  = acc_q + SW'(err) - SW'(oldest);
  assign sum      = acc_q;

  // Ring storage: one register slot per window position
  for (genvar g = 0; g < NMAX; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                ring_q[g] <= '0;
      else if (flip)                             ring_q[g] <= '0;
      else if (stb && (wr_ptr == AW'(g)))        ring_q[g] <= err;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= 1'b0;
      wr_ptr  <= '0;
      acc_q   <= '0;
      sum_vld <= 1'b0;
    end else if (flip) begin
      mode_q  <= half_mode;
      wr_ptr  <= '0;
      acc_q   <= '0;
      sum_vld <= 1'b0;
    end else begin
      sum_vld <= stb;
      if (stb) begin
        acc_q  <= acc_nxt;
        wr_ptr <= (wr_ptr == last_idx) ? '0 : wr_ptr + 1'b1;
      end
    end
  end

endmodule

// File: rtl/swf_comp.sv
module swf_comp
  import swf_pkg::*;
#(
  parameter int SW   = 17,
  parameter int PW   = 16,
  parameter int NOM  = 1000,
  parameter int PMIN = 950,
  parameter int PMAX = 1050,
  parameter int P_SH = 2,
  parameter int I_SH = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic signed [SW-1:0] sum,
  input  logic                 sum_vld,
  output logic [PW-1:0]        word,
  output logic                 word_vld,
  output logic signed [31:0]   integ,
  output logic                 sat_hi,
  output logic                 sat_lo,
  output logic                 frz
);
  comp_t nxt;

  always_comb begin
    nxt    = comp_step(integ, int'(sum), NOM, PMIN, PMAX, P_SH, I_SH);
    sat_hi = nxt.hi;
    sat_lo = nxt.lo;
    frz    = nxt.frz;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      integ    <= '0;
      word     <= PW'(NOM);
      word_vld <= 1'b0;
    end else begin
      word_vld <= sum_vld;
      if (sum_vld) begin
        integ <= nxt.integ;
        word  <= nxt.word[PW-1:0];
      end
    end
  end

endmodule

// File: rtl/swf_loop_filter.sv
module swf_loop_filter #(
  parameter int DW   = 12,
  parameter int NMAX = 16,
  parameter int PW   = 16,
  parameter int NOM  = 1000,
  parameter int P_SH = 2,
  parameter int I_SH = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 half_mode,
  input  logic                 err_stb,
  input  logic signed [DW-1:0] err_in,
  output logic [PW-1:0]        period_word,
  output logic                 period_vld
);
  localparam int SW   = DW + $clog2(NMAX) + 1;
  localparam int PMIN = NOM - NOM / 20;
  localparam int PMAX = NOM + NOM / 20;

  // Named internal events for the checker
  logic signed [SW-1:0] win_sum;
  logic                 win_vld;
  logic                 mode_flip;
  logic signed [31:0]   integ;
  logic                 sat_hi, sat_lo, integ_frz;

  swf_window #(.DW(DW), .NMAX(NMAX)) u_win (
    .clk(clk), .rst_n(rst_n), .half_mode(half_mode),
    .stb(err_stb), .err(err_in),
    .sum(win_sum), .sum_vld(win_vld), .flip(mode_flip)
  );

  swf_comp #(.SW(SW), .PW(PW), .NOM(NOM), .PMIN(PMIN), .PMAX(PMAX),
             .P_SH(P_SH), .I_SH(I_SH)) u_comp (
    .clk(clk), .rst_n(rst_n), .sum(win_sum), .sum_vld(win_vld),
    .word(period_word), .word_vld(period_vld), .integ(integ),
    .sat_hi(sat_hi), .sat_lo(sat_lo), .frz(integ_frz)
  );

endmodule

// File: rtl/swf_loop_filter_chk.sv
module swf_loop_filter_chk #(
  parameter int PW   = 16,
  parameter int SW   = 17,
  parameter int PMIN = 950,
  parameter int PMAX = 1050
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 err_stb,
  input logic                 mode_flip,
  input logic signed [SW-1:0] win_sum,
  input logic                 win_vld,
  input logic signed [31:0]   integ,
  input logic                 integ_frz,
  input logic [PW-1:0]        period_word,
  input logic                 period_vld
);
  // R9
  win_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_stb && !mode_flip) |=> win_vld);
  // R9
  out_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_vld |=> period_vld);
  // R9
  no_spurious_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    period_vld |-> $past(win_vld));
  // R5
  flip_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_flip |=> (!win_vld && win_sum == '0));
  // R7
  word_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    period_vld |-> (int'(period_word) >= PMIN && int'(period_word) <= PMAX));
  // R8
  integ_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_vld && integ_frz) |=> $stable(integ));
  // R6
  integ_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !win_vld |=> $stable(integ));
endmodule

bind swf_loop_filter swf_loop_filter_chk #(
  .PW(PW), .SW(SW), .PMIN(PMIN), .PMAX(PMAX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .err_stb(err_stb), .mode_flip(mode_flip),
  .win_sum(win_sum), .win_vld(win_vld), .integ(integ), .integ_frz(integ_frz),
  .period_word(period_word), .period_vld(period_vld)
);

// File: tb/swf_loop_filter_test.sv
module swf_loop_filter_test;
  localparam int DW = 8, NMAX = 8, PW = 16, NOM = 1000, P_SH = 2, I_SH = 4;
  localparam int LO_B = 950, HI_B = 1050;

  logic clk = 1'b0, rst_n = 1'b0, half_mode = 1'b0, err_stb = 1'b0;
  logic signed [DW-1:0] err_in = '0;
  logic [PW-1:0] period_word;
  logic period_vld;

  int checks = 0, fails = 0, cyc = 0;
  // bench model state
  int hist [NMAX];
  int m_ptr = 0, m_len = NMAX, m_integ = 0, m_word = NOM;

  always #2 clk = ~clk;

  swf_loop_filter #(.DW(DW), .NMAX(NMAX), .PW(PW), .NOM(NOM),
                    .P_SH(P_SH), .I_SH(I_SH)) uut (.*);

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++; checks++;
      $display("FAIL watchdog: run did not end, actual %0d cycles expected < 100000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int fdiv(input int v, input int d);
    int q;
    q = v / d;
    if ((v % d != 0) && (v < 0)) q = q - 1;
    return q;
  endfunction

  // model: sum of the last m_len samples, then PI with clamp and hold
  task automatic model_push(input int v);
    int s, p, i, cand, raw;
    hist[m_ptr] = v;
    m_ptr = (m_ptr + 1) % m_len;
    s = 0;
    for (int k = 0; k < m_len; k++) s += hist[k];
    p = fdiv(s, 1 << P_SH);
    i = fdiv(s, 1 << I_SH);
    cand = m_integ + i;
    raw = NOM + p + cand;
    if (!((raw > HI_B && i > 0) || (raw < LO_B && i < 0))) m_integ = cand;
    raw = NOM + p + m_integ;
    m_word = raw > HI_B ? HI_B : (raw < LO_B ? LO_B : raw);
  endtask

  task automatic model_clear(input bit half);
    for (int k = 0; k < NMAX; k++) hist[k] = 0;
    m_ptr = 0;
    m_len = half ? NMAX / 2 : NMAX;
  endtask

  // R2 R3 R6 R7 R9: one accepted sample, output checked two edges later
  task automatic send(input int v, input string req);
    @(negedge clk);
    err_stb = 1'b1; err_in = DW'(v);
    @(negedge clk);
    err_stb = 1'b0;
    chk(period_vld == 1'b0, "R9 early", int'(period_vld), 0);
    model_push(v);
    @(negedge clk);
    chk(period_vld == 1'b1, "R9 valid", int'(period_vld), 1);
    chk(int'(period_word) == m_word, req, int'(period_word), m_word);
    @(negedge clk);
    chk(period_vld == 1'b0, "R9 one pulse", int'(period_vld), 0);
  endtask

  // R5: mode change with a strobe in the same cycle
  task automatic flip_to(input bit half);
    int held;
    held = m_word;
    @(negedge clk);
    half_mode = half; err_stb = 1'b1; err_in = 8'sd77;
    @(negedge clk);
    err_stb = 1'b0;
    model_clear(half);
    @(negedge clk);
    chk(period_vld == 1'b0, "R5 dropped strobe", int'(period_vld), 0);
    chk(int'(period_word) == held, "R5 word held", int'(period_word), held);
  endtask

  initial begin
    int prev;
    model_clear(1'b0);
    repeat (3) @(negedge clk);
    chk(int'(period_word) == NOM, "R1 reset word", int'(period_word), NOM);
    chk(period_vld == 1'b0, "R1 reset valid", int'(period_vld), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(int'(period_word) == NOM && !period_vld, "R1 after release", int'(period_word), NOM);

    // full window sweep (R2, R3 with half_mode = 0)
    for (int i = 0; i < 40; i++) send(((i * 37) % 41) - 20, "R2 full window");
    // idle gap: no valid without strobe (R9)
    repeat (5) begin
      @(negedge clk);
      chk(period_vld == 1'b0, "R9 idle", int'(period_vld), 0);
    end
    // half window (R3, R5)
    flip_to(1'b1);
    for (int i = 0; i < 40; i++) send(((i * 53 + 11) % 31) - 16, "R3 half window");
    // back to full, zero-mean pattern of one window period (R4)
    flip_to(1'b0);
    prev = 0;
    for (int i = 0; i < 24; i++) begin
      send((i % 2 == 1) ? 50 : -50, "R4 zero-mean");
      if (i >= NMAX) chk(int'(period_word) == prev, "R4 steady word", int'(period_word), prev);
      prev = int'(period_word);
    end
    // drive into the upper clamp, then the lower (R7, R8)
    for (int i = 0; i < 30; i++) send(127, "R7 R8 upper clamp");
    chk(int'(period_word) == HI_B, "R7 upper bound", int'(period_word), HI_B);
    for (int i = 0; i < 30; i++) send(-128, "R7 R8 lower clamp");
    chk(int'(period_word) == LO_B, "R7 lower bound", int'(period_word), LO_B);
    for (int i = 0; i < 20; i++) send(((i * 29) % 23) - 11, "R8 recovery");
    // half window near extremes
    flip_to(1'b1);
    for (int i = 0; i < 16; i++) send((i % 3 == 0) ? -128 : 127, "R3 R7 half extremes");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule